// File: doc/BRIEF.md
# Software SMI Trigger with Release Countdown

This block lets software raise a system management interrupt by writing a register. Once a request has gone out, a block flag stops any further request until a programmable countdown releases it. Each request is sent one of two ways, chosen by a control bit. It either holds a dedicated SMI line high until software acknowledges it, or it sends a single-cycle pulse on one of four interrupt request lines.

The countdown is driven by a prescaler on the system clock. One tick occurs every `TICK_CYCLES` cycles. Software loads a hold count, and the timer runs only when that count is 2 or more. A restart bit lets software rearm the prescaler without reloading the count. A sticky status bit records each request, and software clears it by writing a one to it.

Top module: `smi_trigger`

## Requirements
- R1: After reset, `blocked_o`, `smi_o` and `irq_o` are 0, and both the hold count (address 3) and the status bytes (addresses 5 and 6) read 0.
- R2: Writing address 4 with bit 0 set raises a request only when three conditions hold: the block flag is clear, control bit 7 (address 0) is set, and source-select bit 4 (address 2) is set. Otherwise the write changes neither the status, the block flag nor any output.
- R3: If control bit 4 is 0, a request sets `smi_o` on the write edge. `smi_o` then stays high until a write to address 5 with bit 4 set.
- R4: If control bit 4 is 1, a request does not touch `smi_o`. Instead it drives a one-cycle pulse on `irq_o`. The bit pulsed is set by CPU-select bits [1:0] (address 1): 0 gives bit 10, 1 gives bit 11, 2 gives bit 12 and 3 gives bit 15.
- R5: A request sets the block flag (`blocked_o`) and status bit 4. While the flag is set, trigger writes have no effect.
- R6: Writing ones to the status byte clears those bits. If a request and a clear arrive on the same edge, the request wins. Address 5 reads back only bit 4, and address 6 always reads 0.
- R7: A write to address 3 loads the counter and resets the prescaler. The timer runs afterwards only if the value is 2 or more. A value of 0 or 1 leaves the timer stopped, and the block flag and counter then hold their values.
- R8: While the timer runs, the counter drops by one every `TICK_CYCLES` cycles. When it would reach 1, the counter becomes 0, the timer stops and the block flag clears.
- R9: Writing address 4 with bit 1 set resets the prescaler and runs the timer when the counter is 2 or more. With a smaller counter, this write has no effect.
- R10: The CPU-select register keeps only the bits in mask 0x9F. The control and source-select registers keep all bits. Address 4 and address 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| smi_o | output | 1 | SMI request line |
| irq_o | output | IRQ_W | Interrupt request pulses |
| blocked_o | output | 1 | Block flag |

## Verification
The hardest states to reach are the release edge and a restart that lands in the middle of a tick period. Both depend on the exact prescaler phase, which the ports never show. The bench therefore writes each register on a known clock edge and counts edges from that write. It then samples the counter one cycle before and one cycle on the predicted tick. For the restart, it places the restart write two cycles into a period, so that a restart which fails to reset the prescaler produces a visibly early decrement. Writing a count of 1 while blocked shows that a stopped timer never releases the flag.

// File: rtl/smi_trigger.sv
module smi_trigger #(
  parameter int ADDR_W      = 3,
  parameter int TICK_CYCLES = 7000,
  parameter int IRQ_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              smi_o,
  output logic [IRQ_W-1:0]  irq_o,
  output logic              blocked_o
);

  localparam int PRE_W = $clog2(TICK_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CPU  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STL  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_STH  = ADDR_W'(6);
  localparam logic [7:0] CPU_MASK = 8'h9F;

  logic [7:0]       ctrl_q, cpu_q, src_q, cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic             run_q, blk_q, stat_q, smi_q;
  logic [IRQ_W-1:0] irq_q;
  logic [IRQ_W-1:0] irq_sel;

  wire w_ctrl = wr_en && addr == A_CTRL;
  wire w_cpu  = wr_en && addr == A_CPU;
  wire w_src  = wr_en && addr == A_SRC;
  wire w_cnt  = wr_en && addr == A_CNT;
  wire w_trig = wr_en && addr == A_TRIG;
  wire w_stl  = wr_en && addr == A_STL;

  wire fire    = w_trig && wdata[0] && !blk_q && ctrl_q[7] && src_q[4];
  wire restart = w_trig && wdata[1] && cnt_q >= 8'd2;
  wire tick    = run_q && pre_q == PRE_LAST;
  wire release_blk = !w_cnt && !restart && tick && cnt_q == 8'd2;
  wire ack     = w_stl && wdata[4];

  always_comb begin
    irq_sel = '0;
    case (cpu_q[1:0])
      2'd0:    irq_sel[10] = 1'b1;
      2'd1:    irq_sel[11] = 1'b1;
      2'd2:    irq_sel[12] = 1'b1;
      default: irq_sel[15] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cpu_q  <= '0;
      src_q  <= '0;
    end else begin
      if (w_ctrl) ctrl_q <= wdata;
      if (w_cpu)  cpu_q  <= wdata & CPU_MASK;
      if (w_src)  src_q  <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      pre_q <= '0;
    end else if (w_cnt) begin
      cnt_q <= wdata;
      run_q <= wdata >= 8'd2;
      pre_q <= '0;
    end else if (restart) begin
      run_q <= 1'b1;
      pre_q <= '0;
    end else if (run_q) begin
      if (tick) begin
        pre_q <= '0;
        if (cnt_q == 8'd2) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 8'd1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= 1'b0;
      stat_q <= 1'b0;
      smi_q  <= 1'b0;
      irq_q  <= '0;
    end else begin
      if (fire)             blk_q <= 1'b1;
      else if (release_blk) blk_q <= 1'b0;
      if (fire)     stat_q <= 1'b1;
      else if (ack) stat_q <= 1'b0;
      if (fire && !ctrl_q[4]) smi_q <= 1'b1;
      else if (ack)           smi_q <= 1'b0;
      irq_q <= (fire && ctrl_q[4]) ? irq_sel : '0;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_CPU:   rdata = cpu_q;
      A_SRC:   rdata = src_q;
      A_CNT:   rdata = cnt_q;
      A_STL:   rdata = {3'b000, stat_q, 4'b0000};
      A_STH:   rdata = 8'h00;
      default: rdata = 8'h00;
    endcase
  end

  assign smi_o     = smi_q;
  assign irq_o     = irq_q;
  assign blocked_o = blk_q;

endmodule

// File: rtl/smi_trigger_chk.sv
module smi_trigger_chk #(
  parameter int IRQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             smi_o,
  input logic [IRQ_W-1:0] irq_o,
  input logic             blocked_o,
  input logic [7:0]       cnt_q
);

  // R4
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  // R4
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |=> (irq_o == '0));

  // R5
  smi_needs_clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_o) |-> (blocked_o && !$past(blocked_o)));

  // R5
  irq_needs_clear_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> (blocked_o && !$past(blocked_o)));

  // R8
  release_zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blocked_o) |-> (cnt_q == 8'd0 && $past(cnt_q) == 8'd2));

  // R8
  count_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_en) && cnt_q != $past(cnt_q)) |->
      (cnt_q == $past(cnt_q) - 8'd1 || ($past(cnt_q) == 8'd2 && cnt_q == 8'd0)));

endmodule

bind smi_trigger smi_trigger_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .smi_o(smi_o),
  .irq_o(irq_o), .blocked_o(blocked_o), .cnt_q(cnt_q)
);

// File: tb/smi_trigger_tb.sv
`timescale 1ns/1ps
module smi_trigger_tb;
  localparam int T = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        smi_o;
  logic [15:0] irq_o;
  logic        blocked_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  smi_trigger #(.ADDR_W(3), .TICK_CYCLES(T), .IRQ_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .smi_o(smi_o), .irq_o(irq_o), .blocked_o(blocked_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 blocked", blocked_o, 0);
    chk("R1 smi", smi_o, 0);
    chk("R1 irq", irq_o, 0);
    rd(3'd3, v); chk("R1 count", v, 0);
    rd(3'd5, v); chk("R1 status lo", v, 0);
    rd(3'd6, v); chk("R1 status hi", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R10 cpu mask", v, 8'h9F);
    wr(3'd0, 8'h5A); rd(3'd0, v); chk("R10 ctrl full", v, 8'h5A);
    wr(3'd2, 8'hA5); rd(3'd2, v); chk("R10 src full", v, 8'hA5);
    rd(3'd4, v); chk("R10 trigger reads 0", v, 0);
    rd(3'd7, v); chk("R10 unused reads 0", v, 0);
  endtask

  task automatic t_gating();
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd2, 8'h10); wr(3'd4, 8'h01);
    chk("R2 no enable blocked", blocked_o, 0);
    chk("R2 no enable smi", smi_o, 0);
    rd(3'd5, v); chk("R2 no enable status", v, 0);
    wr(3'd0, 8'h80); wr(3'd2, 8'h00); wr(3'd4, 8'h01);
    chk("R2 no select blocked", blocked_o, 0);
    rd(3'd5, v); chk("R2 no select status", v, 0);
  endtask

  task automatic t_smi_line();
    logic [7:0] v;
    wr(3'd2, 8'h10); wr(3'd4, 8'h01);
    chk("R3 smi set", smi_o, 1);
    chk("R3 irq quiet", irq_o, 0);
    chk("R5 blocked set", blocked_o, 1);
    rd(3'd5, v); chk("R5 status bit4", v, 8'h10);
    rd(3'd6, v); chk("R6 status hi zero", v, 0);
    edges(3); chk("R3 smi held", smi_o, 1);
    wr(3'd5, 8'hEF); chk("R6 other bits no clear", smi_o, 1);
    rd(3'd5, v); chk("R6 status kept", v, 8'h10);
    wr(3'd5, 8'h10); chk("R3 smi cleared", smi_o, 0);
    rd(3'd5, v); chk("R6 status cleared", v, 0);
    chk("R5 still blocked", blocked_o, 1);
    wr(3'd4, 8'h01);
    chk("R5 blocked trigger no smi", smi_o, 0);
    rd(3'd5, v); chk("R5 blocked trigger no status", v, 0);
  endtask

  task automatic t_release();
    logic [7:0] v;
    wr(3'd3, 8'h01); edges(3 * T);
    chk("R7 count 1 keeps block", blocked_o, 1);
    rd(3'd3, v); chk("R7 count 1 stays", v, 8'h01);
    wr(3'd4, 8'h02); edges(3 * T);
    rd(3'd3, v); chk("R9 restart small count ignored", v, 8'h01);
    wr(3'd3, 8'h03);
    edges(T - 1); rd(3'd3, v); chk("R8 before first tick", v, 8'h03);
    edges(1); rd(3'd3, v); chk("R8 first tick", v, 8'h02);
    edges(T - 1); chk("R8 still blocked", blocked_o, 1);
    edges(1); chk("R8 released", blocked_o, 0);
    rd(3'd3, v); chk("R8 count zero", v, 0);
    edges(2 * T); rd(3'd3, v); chk("R8 timer stopped", v, 0);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    wr(3'd3, 8'h04);
    edges(T + 2);
    rd(3'd3, v); chk("R8 decremented", v, 8'h03);
    wr(3'd4, 8'h02);
    edges(T - 1); rd(3'd3, v); chk("R9 restart delays tick", v, 8'h03);
    edges(1); rd(3'd3, v); chk("R9 tick after restart", v, 8'h02);
    wr(3'd3, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    logic [3:0] idx [4] = '{4'd10, 4'd11, 4'd12, 4'd15};
    wr(3'd0, 8'h90);
    for (int i = 0; i < 4; i++) begin
      wr(3'd1, 8'(i));
      wr(3'd4, 8'h01);
      chk("R4 irq pulse", irq_o, 32'(16'h1 << idx[i]));
      chk("R4 smi untouched", smi_o, 0);
      edges(1); chk("R4 pulse ends", irq_o, 0);
      wr(3'd4, 8'h01); chk("R5 no pulse while blocked", irq_o, 0);
      wr(3'd5, 8'h10);
      wr(3'd3, 8'h02); edges(T);
      chk("R8 count 2 releases", blocked_o, 0);
    end
    rd(3'd5, v); chk("R6 clean after acks", v, 0);
  endtask

  task automatic t_race();
    logic [7:0] v;
    wr(3'd0, 8'h80);
    wr(3'd4, 8'h01);
    wr(3'd5, 8'h10);
    wr(3'd3, 8'h02); edges(T);
    wr(3'd4, 8'h01);
    rd(3'd5, v); chk("R6 set after ack", v, 8'h10);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_regs();
    t_gating();
    t_smi_line();
    t_release();
    t_restart();
    t_irq();
    t_race();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule